// File: doc/BRIEF.md
# Registered Inverting Bus Transceiver

This block joins two bidirectional data buses, called A and B, through an inverting path in each direction. Each direction owns a storage register that is loaded from its source bus by its own capture strobe. A per-direction source select chooses whether the driven output carries the live value of the source bus or the stored value. In both cases the bits are complemented on the way through.

An active-low enable and a direction input choose which bus, if either, the block drives. Each bus is modelled as three signals: an input vector, an output vector and an output-enable. A tri-state pad or a simulation model builds the physical bus from these. The capture strobes are sampled on the system clock. A capture takes place in the cycle in which a strobe is seen to rise. All outputs are registered.

Top module: `inv_bus_xcvr`

## Requirements
- R1: Synchronous active-high reset sets both output-enables and both output vectors to zero, and clears both storage registers to zero. Driving a stored value after reset therefore yields all ones.
- R2: The A-to-B store loads `a_in` at the first clock edge where `cap_ab` is high after being low at the previous edge. Holding `cap_ab` high does not load again.
- R3: The B-to-A store loads `b_in` on a low-to-high change of `cap_ba`, by the same rule as R2, independently of the A-to-B store.
- R4: Captures take place whatever the values of `oe_n` and `dir`, including isolation. Both stores may load at the same edge.
- R5: With `oe_n`=0 and `dir`=1, `b_oe` is 1 and `a_oe` is 0.
- R6: With `oe_n`=0 and `dir`=0, `a_oe` is 1 and `b_oe` is 0.
- R7: With `oe_n`=1, both output-enables are 0. Whenever an output-enable is 0, its output vector is zero.
- R8: While B is driven, `b_out` is the bitwise complement of `a_in` when `sel_ab`=0, and the complement of the A-to-B store when `sel_ab`=1.
- R9: While A is driven, `a_out` is the bitwise complement of `b_in` when `sel_ba`=0, and the complement of the B-to-A store when `sel_ba`=1.
- R10: `a_oe` and `b_oe` are never 1 together.
- R11: Every output reflects the inputs as sampled at the previous clock edge, a latency of one cycle. A change in the inputs between edges leaves the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| oe_n | input | 1 | Output enable, active low |
| dir | input | 1 | 1: drive B, 0: drive A |
| sel_ab | input | 1 | B output source: 0 live A, 1 stored |
| sel_ba | input | 1 | A output source: 0 live B, 1 stored |
| cap_ab | input | 1 | Capture strobe for the A-to-B store |
| cap_ba | input | 1 | Capture strobe for the B-to-A store |
| a_in | input | WIDTH | Value seen on bus A |
| a_out | output | WIDTH | Value driven onto bus A |
| a_oe | output | 1 | Drive enable for bus A |
| b_in | input | WIDTH | Value seen on bus B |
| b_out | output | WIDTH | Value driven onto bus B |
| b_oe | output | 1 | Drive enable for bus B |

## Verification
The bench builds the block with the default WIDTH of 8. At that width, mixed patterns such as 0x0F, 0x3C, 0xA5 and 0xFF tell an inverted value apart from a pass-through, a stale value or a cleared value. The bench sets both stores to known, distinct values and then walks enable, direction and both selects. This shows every output source in both directions. Directed sequences then cover a strobe held high, a capture made while the opposite bus is driven, and the one-cycle output latency.

// File: rtl/inv_bus_xcvr_pkg.sv
package inv_bus_xcvr_pkg;

  typedef enum logic [1:0] {
    DRIVE_NONE = 2'd0,
    DRIVE_A    = 2'd1,
    DRIVE_B    = 2'd2
  } drive_e;

  // Map the active-low enable and direction onto the bus to be driven
  function automatic drive_e drive_decode(input logic enable_n, input logic to_b);
    if (enable_n)  return DRIVE_NONE;
    else if (to_b) return DRIVE_B;
    else           return DRIVE_A;
  endfunction

endpackage

// File: rtl/xcvr_edge_det.sv
module xcvr_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  output logic rise
);
  logic strobe_q;

  // Track the strobe during reset too, so a level held through reset is not an edge
  always_ff @(posedge clk) begin
    strobe_q <= strobe;
  end

  assign rise = strobe & ~strobe_q & ~rst;
endmodule

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             drive,
  input  logic             use_stored,
  input  logic [WIDTH-1:0] live,
  input  logic [WIDTH-1:0] stored,
  output logic [WIDTH-1:0] out_q,
  output logic             oe_q
);
  logic [WIDTH-1:0] chosen;

  assign chosen = use_stored ? stored : live;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
      oe_q  <= 1'b0;
    end else begin
      out_q <= drive ? ~chosen : '0;
      oe_q  <= drive;
    end
  end
endmodule

// File: rtl/inv_bus_xcvr.sv
module inv_bus_xcvr
  import inv_bus_xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             oe_n,
  input  logic             dir,
  input  logic             sel_ab,
  input  logic             sel_ba,
  input  logic             cap_ab,
  input  logic             cap_ba,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe
);
  localparam int NDIR = 2;  // index 0: A to B, index 1: B to A

  drive_e           mode;
  logic [NDIR-1:0]  strobe, rise, drive, sel, oe;
  logic [WIDTH-1:0] src    [NDIR];
  logic [WIDTH-1:0] held   [NDIR];
  logic [WIDTH-1:0] result [NDIR];

  assign mode      = drive_decode(oe_n, dir);
  assign strobe    = {cap_ba, cap_ab};
  assign sel       = {sel_ba, sel_ab};
  assign drive[0]  = (mode == DRIVE_B);
  assign drive[1]  = (mode == DRIVE_A);
  assign src[0]    = a_in;
  assign src[1]    = b_in;

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    xcvr_edge_det u_edge (
      .clk    (clk),
      .rst    (rst),
      .strobe (strobe[d]),
      .rise   (rise[d])
    );

    xcvr_store #(.WIDTH(WIDTH)) u_store (
      .clk  (clk),
      .rst  (rst),
      .load (rise[d]),
      .d    (src[d]),
      .q    (held[d])
    );

    xcvr_lane #(.WIDTH(WIDTH)) u_lane (
      .clk        (clk),
      .rst        (rst),
      .drive      (drive[d]),
      .use_stored (sel[d]),
      .live       (src[d]),
      .stored     (held[d]),
      .out_q      (result[d]),
      .oe_q       (oe[d])
    );
  end

  assign b_out = result[0];
  assign b_oe  = oe[0];
  assign a_out = result[1];
  assign a_oe  = oe[1];
endmodule

// File: rtl/inv_bus_xcvr_chk.sv
module inv_bus_xcvr_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             oe_n,
  input logic             dir,
  input logic             sel_ab,
  input logic             sel_ba,
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] b_in,
  input logic [WIDTH-1:0] a_out,
  input logic             a_oe,
  input logic [WIDTH-1:0] b_out,
  input logic             b_oe
);
  AST_ONE_BUS_DRIVEN: assert property (@(posedge clk) disable iff (rst)
    !(a_oe && b_oe)); // R10

  AST_ISOLATE: assert property (@(posedge clk) disable iff (rst)
    $past(oe_n) |-> (!a_oe && !b_oe)); // R7

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    ((!a_oe -> a_out == '0) && (!b_oe -> b_out == '0))); // R7

  AST_DRIVE_B: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(!oe_n && dir)) |-> (b_oe && !a_oe)); // R5

  AST_DRIVE_A: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(!oe_n && !dir)) |-> (a_oe && !b_oe)); // R6

  AST_LIVE_AB: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(!oe_n && dir && !sel_ab)) |-> (b_out == ~$past(a_in))); // R8

  AST_LIVE_BA: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(!oe_n && !dir && !sel_ba)) |-> (a_out == ~$past(b_in))); // R9
endmodule

bind inv_bus_xcvr inv_bus_xcvr_chk #(.WIDTH(WIDTH)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .oe_n   (oe_n),
  .dir    (dir),
  .sel_ab (sel_ab),
  .sel_ba (sel_ba),
  .a_in   (a_in),
  .b_in   (b_in),
  .a_out  (a_out),
  .a_oe   (a_oe),
  .b_out  (b_out),
  .b_oe   (b_oe)
);

// File: tb/inv_bus_xcvr_bench.sv
module inv_bus_xcvr_bench;
  localparam int WIDTH = 8;
  localparam int NVEC  = 10;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             oe_n = 1'b1, dir = 1'b0, sel_ab = 1'b0, sel_ba = 1'b0;
  logic             cap_ab = 1'b0, cap_ba = 1'b0;
  logic [WIDTH-1:0] a_in = '0, b_in = '0;
  logic [WIDTH-1:0] a_out, b_out;
  logic             a_oe, b_oe;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  inv_bus_xcvr #(.WIDTH(WIDTH)) u_inv_bus_xcvr (
    .clk(clk), .rst(rst), .oe_n(oe_n), .dir(dir), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .cap_ab(cap_ab), .cap_ba(cap_ba), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  // {oe_n, dir, sel_ab, sel_ba, a_in, b_in, a_oe, b_oe, a_out, b_out}
  // Stores preloaded: A-to-B = 8'h3C, B-to-A = 8'hA5
  localparam logic [37:0] VEC [NVEC] = '{
    {4'b0100, 8'h0F, 8'hE1, 2'b01, 8'h00, 8'hF0},  // R5 R8 live
    {4'b0110, 8'h0F, 8'hE1, 2'b01, 8'h00, 8'hC3},  // R8 stored
    {4'b0000, 8'h0F, 8'hE1, 2'b10, 8'h1E, 8'h00},  // R6 R9 live
    {4'b0001, 8'h0F, 8'hE1, 2'b10, 8'h5A, 8'h00},  // R9 stored
    {4'b1111, 8'h0F, 8'hE1, 2'b00, 8'h00, 8'h00},  // R7
    {4'b1000, 8'h0F, 8'hE1, 2'b00, 8'h00, 8'h00},  // R7
    {4'b0101, 8'h77, 8'hE1, 2'b01, 8'h00, 8'h88},  // R8
    {4'b0010, 8'h0F, 8'h00, 2'b10, 8'hFF, 8'h00},  // R9
    {4'b0100, 8'hFF, 8'h00, 2'b01, 8'h00, 8'h00},  // R8
    {4'b0011, 8'hFF, 8'h24, 2'b10, 8'h5A, 8'h00}   // R9
  };

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check(input string req, input logic [WIDTH*2+1:0] act,
                       input logic [WIDTH*2+1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [WIDTH*2+1:0] outs();
    return {a_oe, b_oe, a_out, b_out};
  endfunction

  initial begin
    step(3);
    check("R1", outs(), '0);
    rst = 1'b0;
    oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b1;
    step();
    check("R1", outs(), {2'b01, 8'h00, 8'hFF});
    dir = 1'b0; sel_ba = 1'b1;
    step();
    check("R1", outs(), {2'b10, 8'hFF, 8'h00});

    // Load both stores together while isolated (R4)
    oe_n = 1'b1; a_in = 8'h3C; b_in = 8'hA5; cap_ab = 1'b1; cap_ba = 1'b1;
    step();
    check("R4", outs(), '0);
    cap_ab = 1'b0; cap_ba = 1'b0; a_in = 8'h00; b_in = 8'h00;
    step();

    for (int v = 0; v < NVEC; v++) begin
      {oe_n, dir, sel_ab, sel_ba, a_in, b_in} = VEC[v][37:18];
      step();
      check($sformatf("VEC%0d R5-R9", v), outs(), VEC[v][17:0]);
      check("R10", {17'd0, a_oe & b_oe}, '0);
    end

    // R2: a held strobe loads once
    oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b1;
    a_in = 8'h11; cap_ab = 1'b1;
    step();
    a_in = 8'h22;
    step(3);
    check("R2", outs(), {2'b01, 8'h00, 8'hEE});
    cap_ab = 1'b0;
    step(2);
    check("R2", outs(), {2'b01, 8'h00, 8'hEE});
    cap_ab = 1'b1;
    step(2);
    check("R2", outs(), {2'b01, 8'h00, 8'hDD});
    cap_ab = 1'b0;

    // R3 R4: load B-to-A while A is driven
    dir = 1'b0; sel_ba = 1'b1; b_in = 8'h66; cap_ba = 1'b1;
    step(2);
    check("R3", outs(), {2'b10, 8'h99, 8'h00});
    cap_ba = 1'b0; b_in = 8'h00;
    step();
    check("R3", outs(), {2'b10, 8'h99, 8'h00});

    // R11: one-cycle latency
    sel_ba = 1'b0; b_in = 8'h0F;
    step();
    check("R11", outs(), {2'b10, 8'hF0, 8'h00});
    b_in = 8'hF0;
    #2;
    check("R11", outs(), {2'b10, 8'hF0, 8'h00});
    step();
    check("R11", outs(), {2'b10, 8'h0F, 8'h00});

    // R1: reset clears the store again
    rst = 1'b1;
    step();
    check("R1", outs(), '0);
    rst = 1'b0; sel_ba = 1'b1;
    step();
    check("R1", outs(), {2'b10, 8'hFF, 8'h00});

    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule